// File: doc/BRIEF.md
# 32-bit Integer Execution Unit

This block is the integer datapath of a 32-bit RISC core. Each operation reads one or two 32-bit operands, plus a 5-bit shift amount for shifts and rotates, and produces one 32-bit value for the register file to write back. The operation code on `op_i` selects the operation. Addition, subtraction, the three high-word multiplies, the low-word multiply, the relational operations, the logical operations, the shifts and the rotates are combinational. Their result appears on `result_o` in the same cycle as the operands.

Division is iterative and produces one quotient bit per clock. A start pulse given with a divide code captures the operands. `busy_o` stays high for 32 cycles, then `done_o` pulses. The quotient is held and shown on `result_o` whenever `op_i` carries a divide code. Unassigned codes give a zero result and raise `illegal_o`, so that software can emulate the operation.

Top module: `int_exec_unit`

## Requirements
- R1: Codes 0 (add) and 1 (subtract, A minus B) give the 32-bit sum and difference, wrapping modulo 2^32.
- R2: Code 2 gives the low 32 bits of A times B. Codes 3, 4 and 5 give the upper 32 bits of the 64-bit product, with A and B both signed (3), both unsigned (4), or A signed and B unsigned (5).
- R3: The relational codes are 8 (A equal to B), 9 (not equal), 10 (A greater or equal to B, signed), 11 (greater or equal, unsigned), 12 (A less than B, signed) and 13 (less than, unsigned). Each returns 1 when true and 0 when false, with bits 31..1 always zero.
- R4: Codes 14 (AND), 15 (OR), 16 (NOR) and 17 (XOR) act bitwise on A and B.
- R5: Codes 18 (logical left), 19 (logical right) and 20 (arithmetic right) shift A by `shamt_i` positions (0 to 31). An amount of 0 returns A unchanged.
- R6: Codes 21 (rotate left) and 22 (rotate right) rotate A by `shamt_i` positions. An amount of 0 returns A unchanged.
- R7: Codes 23 to 31 give a zero result with `illegal_o` high. Every other code keeps `illegal_o` low.
- R8: A start pulse is accepted when `start_i` is high, `op_i` is 6 (signed divide) or 7 (unsigned divide) and `busy_o` is low at a clock edge k. `busy_o` is then high from edge k through edge k+32. `done_o` is high for exactly the one cycle after edge k+32.
- R9: The quotient is A divided by B, truncated toward zero. It replaces the held value at the edge that raises `done_o`. The held value is shown on `result_o` while `op_i` is 6 or 7 and stays unchanged while a division runs.
- R10: Division by zero returns all ones (-1 when signed). A signed division of 0x80000000 by -1 returns 0x80000000.
- R11: A start while `busy_o` is high, or a start with a code other than 6 or 7, is ignored. It changes neither the running quotient nor its timing.
- R12: After reset, `busy_o` and `done_o` are low and the held quotient is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| shamt_i | input | 5 | Shift or rotate amount |
| start_i | input | 1 | Division start pulse |
| result_o | output | 32 | Operation result |
| illegal_o | output | 1 | Unassigned code flag |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Division finished, one-cycle pulse |

## Verification
The assertions check the following on every cycle:
- a relational result is a single bit;
- an unassigned code gives a zero result;
- a zero shift or rotate amount passes A through unchanged;
- `done_o` lasts one cycle and closes the busy window;
- the iteration counter stays in range and a start during a division does not disturb it;
- the held quotient stays unchanged while busy.

The arithmetic values themselves are shown only by the bench's reference model over its operand patterns:
- the high-word products in all three signedness mixes;
- truncation toward zero for each sign combination;
- the divide-by-zero and overflow quotients;
- the exact 32-cycle latency.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    localparam int XLEN = 32;
    localparam int OPW  = 5;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [OPW-1:0] {
        OP_ADD    = 5'd0,
        OP_SUB    = 5'd1,
        OP_MUL    = 5'd2,
        OP_MULHSS = 5'd3,
        OP_MULHUU = 5'd4,
        OP_MULHSU = 5'd5,
        OP_DIVS   = 5'd6,
        OP_DIVU   = 5'd7,
        OP_CEQ    = 5'd8,
        OP_CNE    = 5'd9,
        OP_CGE    = 5'd10,
        OP_CGEU   = 5'd11,
        OP_CLT    = 5'd12,
        OP_CLTU   = 5'd13,
        OP_AND    = 5'd14,
        OP_OR     = 5'd15,
        OP_NOR    = 5'd16,
        OP_XOR    = 5'd17,
        OP_SLL    = 5'd18,
        OP_SRL    = 5'd19,
        OP_SRA    = 5'd20,
        OP_ROL    = 5'd21,
        OP_ROR    = 5'd22
    } alu_op_e;

    typedef enum logic [2:0] {
        SK_SLL, SK_SRL, SK_SRA, SK_ROL, SK_ROR
    } shift_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
    } prod_t;

    typedef struct packed {
        logic            go;
        logic            sgn;
        logic [XLEN-1:0] dividend;
        logic [XLEN-1:0] divisor;
    } div_req_t;

    function automatic logic is_div(logic [OPW-1:0] code);
        return (code == OP_DIVS) || (code == OP_DIVU);
    endfunction

    function automatic logic is_cmp(logic [OPW-1:0] code);
        return (code >= OP_CEQ) && (code <= OP_CLTU);
    endfunction

    function automatic logic is_shift(logic [OPW-1:0] code);
        return (code >= OP_SLL) && (code <= OP_ROR);
    endfunction

    function automatic shift_kind_e shift_kind(logic [OPW-1:0] code);
        case (code)
            OP_SLL:  return SK_SLL;
            OP_SRL:  return SK_SRL;
            OP_SRA:  return SK_SRA;
            OP_ROL:  return SK_ROL;
            default: return SK_ROR;
        endcase
    endfunction

endpackage

// File: rtl/alu_shift.sv
`timescale 1ns/1ps
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         data_i,
    input  logic [$clog2(W)-1:0] amt_i,
    input  shift_kind_e          kind_i,
    output logic [W-1:0]         data_o
);
    localparam int SW = $clog2(W);

    logic          to_left;
    logic          wrap;
    logic          fill;
    logic [W-1:0]  din;
    logic [W-1:0]  stage [0:SW];

    assign to_left = (kind_i == SK_SLL) || (kind_i == SK_ROL);
    assign wrap    = (kind_i == SK_ROL) || (kind_i == SK_ROR);
    assign fill    = (kind_i == SK_SRA) ? data_i[W-1] : 1'b0;

    // Left operations reuse the right-moving network on bit-reversed data.
    for (genvar i = 0; i < W; i++) begin : g_rev_in
        assign din[i] = to_left ? data_i[W-1-i] : data_i[i];
    end

    assign stage[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [SH-1:0] upper;
        assign upper = wrap ? stage[s][SH-1:0] : {SH{fill}};
        assign stage[s+1] = amt_i[s] ? {upper, stage[s][W-1:SH]} : stage[s];
    end

    for (genvar i = 0; i < W; i++) begin : g_rev_out
        assign data_o[i] = to_left ? stage[SW][W-1-i] : stage[SW][i];
    end

endmodule

// File: rtl/alu_mul.sv
`timescale 1ns/1ps
module alu_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           a_signed_i,
    input  logic           b_signed_i,
    output logic [2*W-1:0] prod_o
);
    logic [2*W-1:0] a_ext;
    logic [2*W-1:0] b_ext;

    // Extending both factors to full product width makes one modular
    // multiply serve every signedness mix.
    assign a_ext  = {{W{a_signed_i & a_i[W-1]}}, a_i};
    assign b_ext  = {{W{b_signed_i & b_i[W-1]}}, b_i};
    assign prod_o = a_ext * b_ext;

endmodule

// File: rtl/alu_div.sv
`timescale 1ns/1ps
module alu_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic         sgn_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] q_o
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic          busy_q;
    logic          done_q;
    logic          neg_q;
    logic          zero_q;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [W-1:0]  res_q;

    logic [W:0]    rem_sh;
    logic          ge;
    logic [W-1:0]  diff;
    logic [W-1:0]  rem_nx;
    logic [W-1:0]  quo_nx;
    logic [W-1:0]  fin;
    logic [W-1:0]  a_mag;
    logic [W-1:0]  b_mag;

    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        ge     = rem_sh >= {1'b0, dvs_q};
        diff   = rem_sh[W-1:0] - dvs_q;
        rem_nx = ge ? diff : rem_sh[W-1:0];
        quo_nx = {quo_q[W-2:0], ge};
        fin    = zero_q ? '1 : (neg_q ? -quo_nx : quo_nx);
        a_mag  = (sgn_i && a_i[W-1]) ? -a_i : a_i;
        b_mag  = (sgn_i && b_i[W-1]) ? -b_i : b_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            neg_q  <= 1'b0;
            zero_q <= 1'b0;
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            res_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (go_i) begin
                    busy_q <= 1'b1;
                    cnt    <= CW'(W);
                    rem_q  <= '0;
                    quo_q  <= a_mag;
                    dvs_q  <= b_mag;
                    neg_q  <= sgn_i & (a_i[W-1] ^ b_i[W-1]);
                    zero_q <= (b_i == '0);
                end
            end else begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                cnt   <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    res_q  <= fin;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign q_o    = res_q;

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8
    AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy_q && $past(busy_q))); // R8
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (cnt >= CW'(1) && cnt <= CW'(W))); // R8
    AST_QUOT_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(res_q)); // R9
    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_q && go_i && cnt > CW'(1)) |=> (busy_q && cnt == $past(cnt) - 1'b1)); // R11

endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
    import alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OPW-1:0]  op_i,
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [SHW-1:0]  shamt_i,
    input  logic            start_i,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_o,
    output logic            busy_o,
    output logic            done_o
);
    alu_op_e         op;
    prod_t           prod;
    div_req_t        dreq;
    logic [XLEN-1:0] shift_res;
    logic [XLEN-1:0] div_q;
    logic            mul_a_sgn;
    logic            mul_b_sgn;
    logic            lt_s;
    logic            lt_u;
    logic            eq;

    assign op = alu_op_e'(op_i);

    assign mul_a_sgn = (op == OP_MULHSS) || (op == OP_MULHSU);
    assign mul_b_sgn = (op == OP_MULHSS);

    alu_mul #(.W(XLEN)) u_mul (
        .a_i        (opa_i),
        .b_i        (opb_i),
        .a_signed_i (mul_a_sgn),
        .b_signed_i (mul_b_sgn),
        .prod_o     (prod)
    );

    alu_shift #(.W(XLEN)) u_shift (
        .data_i (opa_i),
        .amt_i  (shamt_i),
        .kind_i (shift_kind(op_i)),
        .data_o (shift_res)
    );

    always_comb begin
        dreq.go       = start_i && is_div(op_i);
        dreq.sgn      = (op == OP_DIVS);
        dreq.dividend = opa_i;
        dreq.divisor  = opb_i;
    end

    alu_div #(.W(XLEN)) u_div (
        .clk    (clk),
        .rst    (rst),
        .go_i   (dreq.go),
        .sgn_i  (dreq.sgn),
        .a_i    (dreq.dividend),
        .b_i    (dreq.divisor),
        .busy_o (busy_o),
        .done_o (done_o),
        .q_o    (div_q)
    );

    assign eq   = (opa_i == opb_i);
    assign lt_s = ($signed(opa_i) < $signed(opb_i));
    assign lt_u = (opa_i < opb_i);

    always_comb begin
        result_o  = '0;
        illegal_o = 1'b0;
        case (op)
            OP_ADD:    result_o = opa_i + opb_i;
            OP_SUB:    result_o = opa_i - opb_i;
            OP_MUL:    result_o = prod.lo;
            OP_MULHSS,
            OP_MULHUU,
            OP_MULHSU: result_o = prod.hi;
            OP_DIVS,
            OP_DIVU:   result_o = div_q;
            OP_CEQ:    result_o = XLEN'(eq);
            OP_CNE:    result_o = XLEN'(!eq);
            OP_CGE:    result_o = XLEN'(!lt_s);
            OP_CGEU:   result_o = XLEN'(!lt_u);
            OP_CLT:    result_o = XLEN'(lt_s);
            OP_CLTU:   result_o = XLEN'(lt_u);
            OP_AND:    result_o = opa_i & opb_i;
            OP_OR:     result_o = opa_i | opb_i;
            OP_NOR:    result_o = ~(opa_i | opb_i);
            OP_XOR:    result_o = opa_i ^ opb_i;
            OP_SLL,
            OP_SRL,
            OP_SRA,
            OP_ROL,
            OP_ROR:    result_o = shift_res;
            default:   illegal_o = 1'b1;
        endcase
    end

    AST_ILLEGAL_GIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (result_o == '0)); // R7
    AST_CMP_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
        is_cmp(op_i) |-> (result_o[XLEN-1:1] == '0)); // R3
    AST_SHIFT_ZERO_PASSES: assert property (@(posedge clk) disable iff (rst)
        (is_shift(op_i) && shamt_i == '0) |-> (result_o == opa_i)); // R5 R6

endmodule

// File: tb/int_exec_unit_bench.sv
`timescale 1ns/1ps
module int_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op = 5'd7;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  sh = '0;
    logic        start = 1'b0;
    logic [31:0] result;
    logic        illegal;
    logic        busy;
    logic        done;
    logic        mon_en = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    int_exec_unit u_int_exec_unit (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op),
        .opa_i     (opa),
        .opb_i     (opb),
        .shamt_i   (sh),
        .start_i   (start),
        .result_o  (result),
        .illegal_o (illegal),
        .busy_o    (busy),
        .done_o    (done)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string req_of(input int code);
        if (code <= 1) return "R1";
        if (code <= 5) return "R2";
        if (code <= 7) return "R9";
        if (code <= 13) return "R3";
        if (code <= 17) return "R4";
        if (code <= 20) return "R5";
        if (code <= 22) return "R6";
        return "R7";
    endfunction

    function automatic logic [31:0] ref_alu(input int code, input logic [31:0] a, input logic [31:0] b, input logic [4:0] s);
        longint      sa = longint'($signed(a));
        longint      sb = longint'($signed(b));
        longint      ub = longint'({32'b0, b});
        logic [63:0] p;
        case (code)
            0:  return a + b;
            1:  return a - b;
            2:  return a * b;
            3:  begin p = 64'(sa * sb); return p[63:32]; end
            4:  begin p = {32'b0, a} * {32'b0, b}; return p[63:32]; end
            5:  begin p = 64'(sa * ub); return p[63:32]; end
            8:  return (a == b) ? 32'd1 : 32'd0;
            9:  return (a != b) ? 32'd1 : 32'd0;
            10: return ($signed(a) >= $signed(b)) ? 32'd1 : 32'd0;
            11: return (a >= b) ? 32'd1 : 32'd0;
            12: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            13: return (a < b) ? 32'd1 : 32'd0;
            14: return a & b;
            15: return a | b;
            16: return ~(a | b);
            17: return a ^ b;
            18: return a << s;
            19: return a >> s;
            20: return $signed(a) >>> s;
            21: return (a << s) | (a >> (32 - int'(s)));
            22: return (a >> s) | (a << (32 - int'(s)));
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] ref_div(input int code, input logic [31:0] a, input logic [31:0] b);
        int sa, sb;
        if (b == 32'd0) return 32'hFFFF_FFFF;
        if (code == 7) return a / b;
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        sa = $signed(a);
        sb = $signed(b);
        return 32'(sa / sb);
    endfunction

    // Cycle-by-cycle comparison of every combinational result against the model.
    always @(negedge clk) begin
        if (!rst && mon_en && op != 5'd6 && op != 5'd7) begin
            check(result == ref_alu(int'(op), opa, opb, sh), req_of(int'(op)), result, ref_alu(int'(op), opa, opb, sh));
            check(illegal == (op > 5'd22), "R7", {31'b0, illegal}, {31'b0, op > 5'd22});
        end
    end

    task automatic run_div(input logic [4:0] code, input logic [31:0] a, input logic [31:0] b, input bit poke);
        logic [31:0] exp;
        exp = ref_div(int'(code), a, b);
        @(posedge clk); #1;
        op = code; opa = a; opb = b; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R8", {31'b0, busy}, 32'd1);
        for (int i = 1; i <= 32; i++) begin
            @(posedge clk); #1;
            if (poke && i == 4) begin
                start = 1'b1; op = 5'd7; opa = 32'd999; opb = 32'd3;
            end
            if (poke && i == 5) begin
                start = 1'b0; op = code; opa = a; opb = b;
            end
            if (i == 31) begin
                @(negedge clk);
                check(busy == 1'b1 && done == 1'b0, poke ? "R11" : "R8", {30'b0, busy, done}, 32'd2);
            end
            if (i == 32) begin
                @(negedge clk);
                check(done == 1'b1 && busy == 1'b0, poke ? "R11" : "R8", {30'b0, busy, done}, 32'd1);
                check(result == exp, (b == 0 || (a == 32'h8000_0000 && b == '1)) ? "R10" : "R9", result, exp);
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R8", {31'b0, done}, 32'd0);
        check(result == exp, "R9", result, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] pa [0:7];
        logic [31:0] pb [0:7];
        logic [4:0]  shv [0:5];
        logic [31:0] lcg;
        pa[0] = 32'h0;         pb[0] = 32'h0;
        pa[1] = 32'h1;         pb[1] = 32'h1;
        pa[2] = 32'hFFFF_FFFF; pb[2] = 32'h1;
        pa[3] = 32'h8000_0000; pb[3] = 32'hFFFF_FFFF;
        pa[4] = 32'h7FFF_FFFF; pb[4] = 32'h8000_0000;
        pa[5] = 32'h1234_5678; pb[5] = 32'h9ABC_DEF0;
        pa[6] = 32'hDEAD_BEEF; pb[6] = 32'hDEAD_BEEF;
        pa[7] = 32'h0000_0005; pb[7] = 32'hFFFF_FFFB;
        shv[0] = 5'd0; shv[1] = 5'd1; shv[2] = 5'd31;
        shv[3] = 5'd4; shv[4] = 5'd16; shv[5] = 5'd13;
        lcg = 32'h1357_9BDF;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R12", {30'b0, busy, done}, 32'd0);
        check(result == 32'd0, "R12", result, 32'd0);

        // Sweep every non-divide code over fixed and pseudo-random operands.
        mon_en = 1'b1;
        for (int c = 0; c < 32; c++) begin
            if (c == 6 || c == 7) continue;
            for (int p = 0; p < 14; p++) begin
                @(posedge clk); #1;
                op = 5'(c);
                if (p < 8) begin
                    opa = pa[p]; opb = pb[p];
                end else begin
                    lcg = lcg * 32'd1664525 + 32'd1013904223; opa = lcg;
                    lcg = lcg * 32'd1664525 + 32'd1013904223; opb = lcg;
                end
                sh = shv[p % 6];
            end
        end
        mon_en = 1'b0;

        // R11: start with a non-divide code must not begin a division.
        @(posedge clk); #1;
        op = 5'd0; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R11", {31'b0, busy}, 32'd0);
        op = 5'd7;
        @(negedge clk);
        check(result == 32'd0, "R11", result, 32'd0);

        run_div(5'd7, 32'd100, 32'd7, 1'b0);                  // R9
        run_div(5'd6, 32'hFFFF_FF9C, 32'd7, 1'b0);            // R9 -100/7
        run_div(5'd6, 32'd100, 32'hFFFF_FFF9, 1'b0);          // R9 100/-7
        run_div(5'd6, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 1'b0);    // R9 -100/-7
        run_div(5'd7, 32'hFFFF_FFFF, 32'd1, 1'b0);            // R9
        run_div(5'd7, 32'hDEAD_BEEF, 32'h0001_0003, 1'b0);    // R9
        run_div(5'd7, 32'd1234, 32'd0, 1'b0);                 // R10
        run_div(5'd6, 32'hFFFF_FF00, 32'd0, 1'b0);            // R10
        run_div(5'd6, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);    // R10
        run_div(5'd6, 32'd7, 32'd100, 1'b0);                  // R9 zero quotient
        run_div(5'd7, 32'd5000, 32'd17, 1'b1);                // R11 restart ignored

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule